// File: doc/BRIEF.md
# Dual-Compare Timer with Selectable Clear

The block is an 8-bit timer for a peripheral bus. Software picks what makes it count: a divided form of the system clock, or edges on an external clock pin, where the active edge is the rising edge, the falling edge or both. Software also loads two compare constants. The timer raises a flag when the count reaches either constant, and another flag when the count wraps past its top value. Each flag drives an interrupt line through its own enable bit.

The counter can be cleared in one of three ways, chosen by two control bits: by a match against constant A, by a match against constant B, or by a rising edge on an external clear pin. The external pins are not clocked by the system clock. Each one is brought into the system clock domain through a synchronizer and then edge-detected. The resulting edge drives a one-cycle count or clear strobe, so the design has no second clock domain.

Software clears a status flag in two steps. It first reads the status register while the flag is 1, and it then writes 0 to that bit. A new event in the same cycle wins over the clear, so no event is lost.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter reads 0x00, both compare constants read 0xFF, the control byte reads 0x00, the status register reads 0x00 and all three interrupt outputs are low.
- R2: Control bit 7 enables the B-match interrupt, bit 6 the A-match interrupt and bit 5 the overflow interrupt. Each interrupt output is high exactly while its status flag and its enable bit are both 1.
- R3: Status bit 6 (A match) or bit 7 (B match) sets on the clock edge after the counter takes a value equal to that constant. This includes equality reached through a bus write.
- R4: Status bit 5 (overflow) sets on the same edge at which a count event moves the counter from 0xFF to 0x00.
- R5: Control bits 4:3 = 01 select clear on A and 10 select clear on B. In those modes, a count event that arrives while the counter equals the selected constant loads 0x00 instead of incrementing, and it does not set the overflow flag.
- R6: Clear mode 00 never clears the counter. Source code 000 in control bits 2:0 stops the counter entirely.
- R7: Source codes 001, 010 and 011 advance the counter exactly once per 8, 64 and 1024 system-clock cycles respectively.
- R8: Source code 100 counts rising edges of the external clock pin, 101 counts falling edges, and 110 or 111 count both edges. A pin change made between clock edges shows up in the counter at the third following rising edge of the system clock.
- R9: In clear mode 11, a rising edge on the external clear pin zeroes the counter with the same three-edge latency, and it overrides a count event in the same cycle. In every other mode the pin has no effect.
- R10: A flag clears only when a status read sees that flag at 1 and a later status write puts 0 in its bit. A write of 0 without such a read, or a write of 1, leaves the flag set. Any status write disarms every pending clear.
- R11: When a flag's set event coincides with the status write that would clear it, the flag stays set.
- R12: Bus addresses are 0 for the counter, 1 for constant A, 2 for constant B, 3 for control and 4 for status. Read data is valid in the same cycle as the address. A write to the counter takes effect at that edge and overrides any count or clear in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of the status register arms flag clearing |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register, combinational |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| ext_clr_pin | input | 1 | External counter clear, asynchronous |
| irq_cmpa | output | 1 | A-match interrupt request |
| irq_cmpb | output | 1 | B-match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Each result has its own latency. Register writes are visible right after their write edge. An external pin change reaches the counter at the third rising edge after it is driven, because two edges go to the synchronizer and one to the counter. Overflow appears together with the wrap, and a match flag follows one edge after the counter takes the matching value. The bench drives every input on the falling edge and reads outputs by peeking at the address without crossing an edge. Precise-latency tests count edges one by one. The prescaler tests open and close the source select exactly 8K, 64K or 1024K edges apart, so the increment count does not depend on the prescaler phase. The coincidence test for R11 places the status write on the third edge after a pin change, which is the edge at which the wrap happens.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_TAPS = 3;
  localparam int unsigned N_FLAGS = 3;
  // flag i (0 = overflow, 1 = A match, 2 = B match) sits at bit FLAG_BASE+i
  // of the status register; its enable sits at the same bit of control
  localparam int unsigned FLAG_BASE = 5;
  localparam int unsigned CLR_LO = 3;
  localparam int unsigned CLR_HI = 4;

  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  typedef enum logic [1:0] {
    CLR_NEVER = 2'b00,
    CLR_ON_A  = 2'b01,
    CLR_ON_B  = 2'b10,
    CLR_ON_PIN = 2'b11
  } clr_mode_e;

  typedef enum logic [2:0] {
    SRC_STOP   = 3'b000,
    SRC_DIV_LO = 3'b001,
    SRC_DIV_MD = 3'b010,
    SRC_DIV_HI = 3'b011,
    SRC_X_RISE = 3'b100,
    SRC_X_FALL = 3'b101,
    SRC_X_BOTH = 3'b110,
    SRC_X_BOTH2 = 3'b111
  } src_sel_e;

  function automatic logic rise_of(input logic now, input logic last);
    return now & ~last;
  endfunction

  function automatic logic fall_of(input logic now, input logic last);
    return ~now & last;
  endfunction

  // one-cycle count strobe for the chosen source
  function automatic logic pick_tick(input src_sel_e s, input logic [N_TAPS-1:0] pre,
                                     input logic xr, input logic xf);
    logic t;
    unique case (s)
      SRC_STOP:   t = 1'b0;
      SRC_DIV_LO: t = pre[0];
      SRC_DIV_MD: t = pre[1];
      SRC_DIV_HI: t = pre[2];
      SRC_X_RISE: t = xr;
      SRC_X_FALL: t = xf;
      default:    t = xr | xf;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic now,
  output logic last
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign now  = sh_q[STAGES-1];
  assign last = sh_q[STAGES];
endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned LOG2_0 = 3,
  parameter int unsigned LOG2_1 = 6,
  parameter int unsigned LOG2_2 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick
);
  localparam int unsigned MAX01 = (LOG2_0 > LOG2_1) ? LOG2_0 : LOG2_1;
  localparam int unsigned PRE_W = (MAX01 > LOG2_2) ? MAX01 : LOG2_2;
  localparam int unsigned LOG2S [3] = '{LOG2_0, LOG2_1, LOG2_2};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  // When the low bits are all ones, the divided clock (the top bit of the
  // tap) is about to fall: that falling edge is the count event.
  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign tick[g] = &pre_q[LOG2S[g]-1:0];
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pin_clr,
  input  clr_mode_e        clr_mode,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_ma,
  output logic             evt_mb,
  output logic             evt_ovf
);
  logic eq_a, eq_b, eq_a_q, eq_b_q, match_clr;
  logic [CNT_W-1:0] cnt_n;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic to_zero);
    return to_zero ? '0 : c + CNT_W'(1);
  endfunction

  function automatic logic hits_clear(input clr_mode_e m, input logic a, input logic b);
    return (m == CLR_ON_A && a) || (m == CLR_ON_B && b);
  endfunction

  assign eq_a      = (cnt == cmp_a);
  assign eq_b      = (cnt == cmp_b);
  assign match_clr = hits_clear(clr_mode, eq_a, eq_b);

  // match events fire on the transition into equality
  assign evt_ma  = eq_a & ~eq_a_q;
  assign evt_mb  = eq_b & ~eq_b_q;
  assign evt_ovf = tick & ~load & ~pin_clr & ~match_clr & (&cnt);

  always_comb begin
    cnt_n = cnt;
    if (load)         cnt_n = load_val;
    else if (pin_clr) cnt_n = '0;
    else if (tick)    cnt_n = step(cnt, match_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      eq_a_q <= 1'b0;
      eq_b_q <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      eq_a_q <= eq_a;
      eq_b_q <= eq_b;
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV0_LOG2   = 3,
  parameter int unsigned DIV1_LOG2   = 6,
  parameter int unsigned DIV2_LOG2   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk_pin,
  input  logic              ext_clr_pin,
  output logic              irq_cmpa,
  output logic              irq_cmpb,
  output logic              irq_ovf
);
  logic [7:0]        ctrl_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, cnt;
  logic              wr_cnt, wr_cmpa, wr_cmpb, wr_ctrl, wr_stat, rd_stat;
  clr_mode_e         clr_mode;
  src_sel_e          src;
  logic [N_TAPS-1:0] pre_tick;
  logic              xc_now, xc_last, xr_now, xr_last;
  logic              tick, pin_clr;
  logic              evt_ma, evt_mb, evt_ovf;
  logic [N_FLAGS-1:0] set_evt, flags, irq_vec;

  // bus decode
  assign wr_cnt  = bus_wr && (bus_addr == ADDR_CNT);
  assign wr_cmpa = bus_wr && (bus_addr == ADDR_CMPA);
  assign wr_cmpb = bus_wr && (bus_addr == ADDR_CMPB);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '1;
      cmp_b_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q  <= bus_wdata[7:0];
      if (wr_cmpa) cmp_a_q <= bus_wdata;
      if (wr_cmpb) cmp_b_q <= bus_wdata;
    end
  end

  assign clr_mode = clr_mode_e'(ctrl_q[CLR_HI:CLR_LO]);
  assign src      = src_sel_e'(ctrl_q[2:0]);

  // count sources
  dct_prescaler #(
    .LOG2_0(DIV0_LOG2),
    .LOG2_1(DIV1_LOG2),
    .LOG2_2(DIV2_LOG2)
  ) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (pre_tick)
  );

  dct_edge_sync #(.STAGES(SYNC_STAGES)) u_xclk (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_clk_pin),
    .now  (xc_now),
    .last (xc_last)
  );

  dct_edge_sync #(.STAGES(SYNC_STAGES)) u_xclr (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_clr_pin),
    .now  (xr_now),
    .last (xr_last)
  );

  assign tick    = pick_tick(src, pre_tick, rise_of(xc_now, xc_last), fall_of(xc_now, xc_last));
  assign pin_clr = (clr_mode == CLR_ON_PIN) && rise_of(xr_now, xr_last);

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pin_clr (pin_clr),
    .clr_mode(clr_mode),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .load    (wr_cnt),
    .load_val(bus_wdata),
    .cnt     (cnt),
    .evt_ma  (evt_ma),
    .evt_mb  (evt_mb),
    .evt_ovf (evt_ovf)
  );

  // status flags: read-arms, write-0 clears, set wins
  assign set_evt = {evt_mb, evt_ma, evt_ovf};

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    localparam int unsigned POS = FLAG_BASE + i;
    logic flag_r, arm_r, clr_req;

    assign clr_req = wr_stat && arm_r && !bus_wdata[POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_r <= 1'b0;
        arm_r  <= 1'b0;
      end else begin
        flag_r <= set_evt[i] | (flag_r & ~clr_req);
        if (wr_stat)               arm_r <= 1'b0;
        else if (rd_stat && flag_r) arm_r <= 1'b1;
      end
    end

    assign flags[i]   = flag_r;
    assign irq_vec[i] = flag_r & ctrl_q[POS];
  end

  assign irq_ovf  = irq_vec[0];
  assign irq_cmpa = irq_vec[1];
  assign irq_cmpb = irq_vec[2];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CNT:  bus_rdata = cnt;
      ADDR_CMPA: bus_rdata = cmp_a_q;
      ADDR_CMPB: bus_rdata = cmp_b_q;
      ADDR_CTRL: bus_rdata[7:0] = ctrl_q;
      ADDR_STAT: bus_rdata[FLAG_BASE +: N_FLAGS] = flags;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic              irq_cmpa,
  input logic [7:0]        ctrl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp_a,
  input logic              tick,
  input logic              pin_clr,
  input logic              evt_ma,
  input logic              evt_ovf,
  input logic [2:0]        flags
);
  logic wr_cnt;
  assign wr_cnt = bus_wr && (bus_addr == ADDR_CNT);

  AST_IRQ_A_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpa |-> (ctrl[6] && flags[1])); // R2

  AST_MATCH_A_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ma |=> flags[1]); // R3

  AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> (cnt == '0 && flags[0])); // R4

  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[4:3] == 2'b01 && cnt == cmp_a && !wr_cnt) |=> cnt == '0); // R5

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'b000 && !wr_cnt && !pin_clr) |=> $stable(cnt)); // R6

  AST_PIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clr && !wr_cnt) |=> cnt == '0); // R9

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> flags[0]); // R11

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(bus_wdata)); // R12
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .irq_cmpa (irq_cmpa),
  .ctrl     (ctrl_q),
  .cnt      (cnt),
  .cmp_a    (cmp_a_q),
  .tick     (tick),
  .pin_clr  (pin_clr),
  .evt_ma   (evt_ma),
  .evt_ovf  (evt_ovf),
  .flags    (flags)
);

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  localparam logic [2:0] A_CNT = 3'd0, A_CMPA = 3'd1, A_CMPB = 3'd2, A_CTRL = 3'd3, A_STAT = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_pin = 1'b0, ext_clr_pin = 1'b0;
  logic       irq_cmpa, irq_cmpb, irq_ovf;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_pin(ext_clk_pin),
    .ext_clr_pin(ext_clr_pin), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic peek(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    v = int'(bus_rdata);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic clear_flags();
    int v;
    bus_read(A_STAT, v);
    bus_write(A_STAT, 8'h00);
  endtask

  task automatic ext_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    peek(A_CNT, v);  chk("R1", "counter", v, 8'h00);
    peek(A_CMPA, v); chk("R1", "const A", v, 8'hFF);
    peek(A_CMPB, v); chk("R1", "const B", v, 8'hFF);
    peek(A_CTRL, v); chk("R1", "control", v, 8'h00);
    peek(A_STAT, v); chk("R1", "status", v, 8'h00);
    chk("R1", "irqs", {irq_cmpb, irq_cmpa, irq_ovf}, 0);
  endtask

  task automatic t_bus();
    int v;
    bus_write(A_CMPA, 8'h5A); peek(A_CMPA, v); chk("R12", "const A readback", v, 8'h5A);
    bus_write(A_CMPB, 8'hA5); peek(A_CMPB, v); chk("R12", "const B readback", v, 8'hA5);
    bus_write(A_CNT, 8'h33);  peek(A_CNT, v);  chk("R12", "counter readback", v, 8'h33);
    bus_write(A_CMPA, 8'hFF); bus_write(A_CMPB, 8'hFF);
  endtask

  task automatic t_stop();
    int v;
    bus_write(A_CTRL, 8'h00);
    bus_write(A_CNT, 8'h10);
    ext_pulse(2);
    repeat (20) @(negedge clk);
    peek(A_CNT, v); chk("R6", "stopped counter holds", v, 8'h10);
    bus_write(A_CTRL, 8'h04);
    ext_clr_pin = 1'b1; repeat (5) @(negedge clk); ext_clr_pin = 1'b0; repeat (5) @(negedge clk);
    peek(A_CNT, v); chk("R9", "clear pin ignored in mode 00", v, 8'h10);
  endtask

  task automatic t_latency();
    int v;
    bus_write(A_CTRL, 8'h04);
    bus_write(A_CNT, 8'h00);
    ext_clk_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    peek(A_CNT, v); chk("R8", "no count after two edges", v, 0);
    @(posedge clk); @(negedge clk);
    peek(A_CNT, v); chk("R8", "count at third edge", v, 1);
    ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    peek(A_CNT, v); chk("R8", "falling edge ignored in rise mode", v, 1);
  endtask

  task automatic t_ext_modes();
    int v;
    bus_write(A_CTRL, 8'h04); bus_write(A_CNT, 8'h00); ext_pulse(3);
    peek(A_CNT, v); chk("R8", "rise mode 3 pulses", v, 3);
    bus_write(A_CTRL, 8'h05); bus_write(A_CNT, 8'h00); ext_pulse(3);
    peek(A_CNT, v); chk("R8", "fall mode 3 pulses", v, 3);
    bus_write(A_CTRL, 8'h06); bus_write(A_CNT, 8'h00); ext_pulse(3);
    peek(A_CNT, v); chk("R8", "both mode 110", v, 6);
    bus_write(A_CTRL, 8'h07); bus_write(A_CNT, 8'h00); ext_pulse(2);
    peek(A_CNT, v); chk("R8", "both mode 111", v, 4);
  endtask

  task automatic prescale_run(input logic [7:0] sel, input int div, input int k);
    int v;
    bus_write(A_CTRL, 8'h00);
    bus_write(A_CNT, 8'h00);
    bus_write(A_CTRL, sel);
    repeat (div * k - 1) @(posedge clk);
    @(negedge clk);
    bus_write(A_CTRL, 8'h00);
    peek(A_CNT, v); chk("R7", $sformatf("divide by %0d", div), v, k);
  endtask

  task automatic t_prescale();
    prescale_run(8'h01, 8, 20);
    prescale_run(8'h02, 64, 3);
    prescale_run(8'h03, 1024, 1);
  endtask

  task automatic t_match_irq();
    int v;
    bus_write(A_CTRL, 8'h04);
    bus_write(A_CNT, 8'h00);
    bus_write(A_CMPA, 8'h05);
    clear_flags();
    ext_pulse(4);
    peek(A_STAT, v); chk("R3", "A flag before match", v & 8'h40, 0);
    ext_pulse(1);
    peek(A_STAT, v); chk("R3", "A flag at match", v & 8'h40, 8'h40);
    chk("R2", "irq A gated off", irq_cmpa, 0);
    bus_write(A_CTRL, 8'h44);
    chk("R2", "irq A enabled", irq_cmpa, 1);
    bus_write(A_CTRL, 8'h84);
    bus_write(A_CMPB, 8'h07);
    chk("R2", "irq A disabled again", irq_cmpa, 0);
    ext_pulse(2);
    peek(A_STAT, v); chk("R3", "B flag at match", v & 8'h80, 8'h80);
    chk("R2", "irq B enabled", irq_cmpb, 1);
    bus_write(A_CMPB, 8'hFF);
  endtask

  task automatic t_flag_clear();
    int v;
    bus_write(A_STAT, 8'h00);
    peek(A_STAT, v); chk("R10", "write 0 without read", v, 8'hC0);
    bus_read(A_STAT, v);
    bus_write(A_STAT, 8'hFF);
    peek(A_STAT, v); chk("R10", "write 1 keeps flags", v, 8'hC0);
    bus_write(A_STAT, 8'h00);
    peek(A_STAT, v); chk("R10", "prior write disarmed", v, 8'hC0);
    bus_read(A_STAT, v);
    bus_write(A_STAT, 8'h7F);
    peek(A_STAT, v); chk("R10", "clear B only", v, 8'h40);
    bus_read(A_STAT, v);
    bus_write(A_STAT, 8'h00);
    peek(A_STAT, v); chk("R10", "clear A", v, 8'h00);
    chk("R2", "irqs low after clear", {irq_cmpb, irq_cmpa, irq_ovf}, 0);
  endtask

  task automatic t_clear_modes();
    int v;
    bus_write(A_CTRL, 8'h0C);
    bus_write(A_CMPA, 8'h03);
    bus_write(A_CNT, 8'h00);
    clear_flags();
    ext_pulse(3);
    peek(A_CNT, v); chk("R5", "reach A", v, 3);
    ext_pulse(1);
    peek(A_CNT, v); chk("R5", "cleared on A", v, 0);
    peek(A_STAT, v); chk("R5", "no overflow on clear", v & 8'h20, 0);
    bus_write(A_CTRL, 8'h14);
    bus_write(A_CMPA, 8'hFF);
    bus_write(A_CMPB, 8'h02);
    bus_write(A_CNT, 8'h00);
    ext_pulse(3);
    peek(A_CNT, v); chk("R5", "cleared on B", v, 0);
    bus_write(A_CTRL, 8'h04);
    bus_write(A_CMPA, 8'h02);
    bus_write(A_CMPB, 8'hFF);
    bus_write(A_CNT, 8'h00);
    ext_pulse(3);
    peek(A_CNT, v); chk("R6", "no clear in mode 00", v, 3);
    bus_write(A_CMPA, 8'hFF);
  endtask

  task automatic t_overflow();
    int v;
    bus_write(A_CTRL, 8'h24);
    bus_write(A_CNT, 8'hFE);
    clear_flags();
    ext_pulse(1);
    peek(A_STAT, v); chk("R4", "no overflow at 0xFF", v & 8'h20, 0);
    ext_pulse(1);
    peek(A_CNT, v);  chk("R4", "wrapped counter", v, 0);
    peek(A_STAT, v); chk("R4", "overflow flag", v & 8'h20, 8'h20);
    chk("R2", "irq overflow", irq_ovf, 1);
  endtask

  task automatic t_set_beats_clear();
    int v;
    bus_read(A_STAT, v);
    bus_write(A_CNT, 8'hFF);
    ext_clk_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    peek(A_STAT, v); chk("R11", "overflow survives clear", v & 8'h20, 8'h20);
    peek(A_CNT, v);  chk("R11", "wrap on write edge", v, 0);
    ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    clear_flags();
    peek(A_STAT, v); chk("R10", "overflow clears later", v & 8'h20, 0);
  endtask

  task automatic t_pin_clear();
    int v;
    bus_write(A_CTRL, 8'h1C);
    bus_write(A_CNT, 8'h40);
    ext_clr_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    peek(A_CNT, v); chk("R9", "no clear after two edges", v, 8'h40);
    @(posedge clk); @(negedge clk);
    peek(A_CNT, v); chk("R9", "cleared at third edge", v, 0);
    ext_clr_pin = 1'b0; repeat (4) @(negedge clk);
    ext_pulse(2);
    peek(A_CNT, v); chk("R9", "counts again after clear", v, 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus();
    t_stop();
    t_latency();
    t_ext_modes();
    t_prescale();
    t_match_irq();
    t_flag_clear();
    t_clear_modes();
    t_overflow();
    t_set_beats_clear();
    t_pin_clear();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule